// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned N-bit numbers using one full adder over N clock cycles. Two shift registers hold the operands. A single carry flip-flop links one bit position to the next. Each cycle the least significant bits of both registers, together with the stored carry, go into the full adder. The sum bit enters the top of the first register as both registers move right by one place.

When the N add cycles are over, the first register holds the N-bit sum and the carry flip-flop holds bit N of the result. A `mode` input selects between the two operations:

- **Load** (`mode` = 0): both registers take new operands, and the carry and the cycle counter are cleared.
- **Add** (`mode` = 1): the block steps once per clock until N steps are done. It then raises `done` and freezes until the next load.

One clock drives the whole block. Load and shift are clock enables, not separate clocks.

Top module: `serial_shift_adder`

## Requirements
- R1: A synchronous active-high `rst` leaves `sum`, `carry_out` and `done` all at 0 on the following cycle.
- R2: A clock edge with `mode` = 0 and `rst` = 0 loads `opa` into the result register and `opb` into the second register. The same edge clears `carry_out` and `done`.
- R3: On each add step, the result register moves right by one bit and the new sum bit enters at bit N-1. After k steps, `sum` equals sum bits k-1..0 in bits N-1..N-k, with `opa >> k` below them. The second register fills with 0 at its top.
- R4: After k add steps, `carry_out` equals the carry out of adding the low k bits of the two operands.
- R5: After exactly N add steps, `done` is 1, `sum` equals (opa+opb) mod 2^N, and `carry_out` equals bit N of opa+opb.
- R6: While `done` is 1 and `mode` stays 1, `sum`, `carry_out` and `done` do not change.
- R7: `done` stays 0 during the first N-1 add steps after a load.
- R8: Returning `mode` to 0 partway through an addition discards it. The next addition then runs a full N steps from the new operands.
- R9: `rst` takes priority over a load on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = load operands, 1 = add one bit per clock |
| opa | input | N | First operand, loaded into the result register |
| opb | input | N | Second operand |
| sum | output | N | Result register contents |
| carry_out | output | 1 | Carry flip-flop; bit N of the result once done |
| done | output | 1 | High after N add steps, until the next load or reset |

## Verification
The bench compares the partial state after every single step against a closed-form arithmetic model, not just the final sum:

- **Carry chain:** all-ones operands and 0x80+0x80 stress carry propagation. A design that dropped or mis-timed the carry would show a wrong top bit or a lost `carry_out`.
- **Step counting:** checking `done` at step N-1 and step N catches an off-by-one counter. Such a design would raise `done` early or would shift one extra time and corrupt the sum.
- **Holding after done:** extra add cycles after `done` expose a design that keeps shifting.
- **Reload mid-add:** a reload partway through exposes a stale carry or counter.
- **Reset against load:** asserting reset together with a load exposes a wrong priority.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_ADD  = 1'b1
  } ssa_mode_e;

endpackage

// File: rtl/ssa_shift_reg.sv
module ssa_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [W-1:0] load_val,
  input  logic         fill_bit,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (shift_en) begin
      q <= {fill_bit, q[W-1:1]};
    end
  end

  // R3: the bit entering at the top is the fill input of the step before
  a_r3_fill_enters_top: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> q[W-1] == $past(fill_bit));

endmodule

// File: rtl/ssa_full_adder.sv
module ssa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);

  always_comb begin
    s    = a ^ b ^ cin;
    cout = (a & b) | (cin & (a ^ b));
  end

endmodule

// File: rtl/ssa_sequencer.sv
module ssa_sequencer #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic add_req,
  output logic step_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(N + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    step_o = add_req && !load_en && !done_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (load_en) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (step_o) begin
      cnt_q  <= cnt_q + 1'b1;
      done_o <= (cnt_q == LAST);
    end
  end

  // R5: done only rises right after a step was taken
  a_r5_done_after_step: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(step_o));

  // R7: while not done, fewer than N steps have been taken
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> cnt_q < CNT_W'(N));

endmodule

// File: rtl/serial_shift_adder.sv
module serial_shift_adder
  import ssa_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic [N-1:0] sum,
  output logic         carry_out,
  output logic         done
);

  logic         load_en;
  logic         add_req;
  logic         step;
  logic [N-1:0] r1_q;
  logic [N-1:0] r2_q;
  logic         fa_s;
  logic         fa_c;
  logic         carry_q;

  always_comb begin
    load_en = (ssa_mode_e'(mode) == MODE_LOAD);
    add_req = (ssa_mode_e'(mode) == MODE_ADD);
  end

  ssa_sequencer #(.N(N)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .add_req (add_req),
    .step_o  (step),
    .done_o  (done)
  );

  ssa_full_adder fa_i (
    .a    (r1_q[0]),
    .b    (r2_q[0]),
    .cin  (carry_q),
    .s    (fa_s),
    .cout (fa_c)
  );

  ssa_shift_reg #(.W(N)) r1_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .shift_en (step),
    .load_val (opa),
    .fill_bit (fa_s),
    .q        (r1_q)
  );

  ssa_shift_reg #(.W(N)) r2_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .shift_en (step),
    .load_val (opb),
    .fill_bit (1'b0),
    .q        (r2_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (load_en) begin
      carry_q <= 1'b0;
    end else if (step) begin
      carry_q <= fa_c;
    end
  end

  always_comb begin
    sum       = r1_q;
    carry_out = carry_q;
  end

  // R1, R9: reset wins over everything
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (r1_q == '0) && !carry_q && !done);

  // R2: load captures both operands and clears carry and done
  a_r2_load_takes_operands: assert property (@(posedge clk) disable iff (rst)
    !mode |=> (r1_q == $past(opa)) && (r2_q == $past(opb)) && !carry_q && !done);

  // R3: lower bits of the result register come from one place higher
  a_r3_r1_shift: assert property (@(posedge clk) disable iff (rst)
    step |=> r1_q[N-2:0] == $past(r1_q[N-1:1]));

  // R3: second operand register shifts with zero fill
  a_r3_r2_zero_fill: assert property (@(posedge clk) disable iff (rst)
    step |=> r2_q == ($past(r2_q) >> 1));

  // R6: frozen once done while add mode is held
  a_r6_hold_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && mode) |=> $stable(r1_q) && $stable(carry_q) && done);

endmodule

// File: tb/serial_shift_adder_tb_top.sv
module serial_shift_adder_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode;
  logic [N-1:0] opa;
  logic [N-1:0] opb;
  logic [N-1:0] sum;
  logic         carry_out;
  logic         done;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_shift_adder #(.N(N)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .opa       (opa),
    .opb       (opb),
    .sum       (sum),
    .carry_out (carry_out),
    .done      (done)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_r1(input logic [N-1:0] a,
                                          input logic [N-1:0] b, input int k);
    logic [N:0]   s;
    logic [N-1:0] t;
    s = {1'b0, a} + {1'b0, b};
    t = s[N-1:0] << (N - k);
    if (k == 0) t = '0;
    return t | (a >> k);
  endfunction

  function automatic logic exp_c(input logic [N-1:0] a,
                                 input logic [N-1:0] b, input int k);
    logic [N+1:0] m;
    logic [N+1:0] t;
    m = ({{(N+1){1'b0}}, 1'b1} << k) - 1'b1;
    t = ({2'b00, a} & m) + ({2'b00, b} & m);
    return t[k];
  endfunction

  task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b);
    mode = 1'b0; opa = a; opb = b;
    tick();
    chk(sum == a && !carry_out && !done, "R2 load", {sum, carry_out, done},
        {a, 2'b00});
  endtask

  task automatic run_pair(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] full;
    full = {1'b0, a} + {1'b0, b};
    do_load(a, b);
    mode = 1'b1;
    for (int k = 1; k <= N; k++) begin
      tick();
      chk(sum == exp_r1(a, b, k), "R3 partial sum", sum, exp_r1(a, b, k));
      chk(carry_out == exp_c(a, b, k), "R4 carry", carry_out, exp_c(a, b, k));
      if (k < N) chk(!done, "R7 done early", done, 0);
    end
    chk(done == 1'b1, "R5 done", done, 1);
    chk({carry_out, sum} == full, "R5 result", {carry_out, sum}, full);
    for (int j = 0; j < 3; j++) begin
      tick();
      chk({done, carry_out, sum} == {1'b1, full}, "R6 hold",
          {done, carry_out, sum}, {1'b1, full});
    end
  endtask

  initial begin
    logic [N-1:0] ra, rb;
    logic [N:0]   full;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; mode = 1'b0; opa = 8'hFF; opb = 8'h0F;
    tick();
    tick();
    // R1 and R9: reset held together with a load
    chk(sum == '0 && !carry_out && !done, "R1 R9 reset state",
        {sum, carry_out, done}, 0);
    rst = 1'b0;
    tick();
    chk(sum == 8'hFF && !carry_out && !done, "R2 after reset", sum, 8'hFF);

    run_pair(8'h00, 8'h00);
    run_pair(8'hFF, 8'hFF);
    run_pair(8'hFF, 8'h01);
    run_pair(8'h80, 8'h80);
    run_pair(8'hAA, 8'h55);
    run_pair(8'h01, 8'hFF);

    // R8: reload partway through an addition
    do_load(8'hFF, 8'hFF);
    mode = 1'b1;
    tick(); tick(); tick();
    chk(carry_out == 1'b1, "R8 mid-add carry", carry_out, 1);
    do_load(8'h12, 8'h34);
    chk(!carry_out, "R8 reload clears carry", carry_out, 0);
    mode = 1'b1;
    full = 9'h046;
    for (int k = 1; k <= N; k++) begin
      tick();
      if (k < N) chk(!done, "R8 R7 full step count", done, 0);
    end
    chk(done && {carry_out, sum} == full, "R8 result", {carry_out, sum}, full);

    // R9: reset while an addition is in progress
    do_load(8'hC3, 8'h3C);
    mode = 1'b1;
    tick();
    rst = 1'b1; mode = 1'b0;
    tick();
    chk(sum == '0 && !carry_out && !done, "R9 reset mid-add",
        {sum, carry_out, done}, 0);
    rst = 1'b0;

    for (int i = 0; i < 40; i++) begin
      ra = N'($urandom());
      rb = N'($urandom());
      run_pair(ra, rb);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule